// File: doc/BRIEF.md
# Accumulator and Link-Bit Unit

This block is the arithmetic heart of a small accumulator machine. It holds a 16-bit accumulator and a one-bit link flag, and it holds the adder and logic network that computes their next values. A sequencer elsewhere raises one operation strobe per clock. The strobe either combines the accumulator with a data-register word, takes a character from the input register, or reshapes the accumulator in place: complement, clear, increment, or rotate through the link. Two further strobes act on the link alone.

Inside, the strobes are turned into three accumulator controls: a parallel load from the adder and logic network, a count-up, and a clear. Registered status flags give the sign, zero and link-zero conditions that the sequencer needs for its skip tests. These flags are valid in the same cycle as the accumulator value they describe. Bus steering and instruction decode stay with the caller.

Top module: `acc_link_unit`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, the accumulator is 0 and the link is 0, with ac_pos=1, ac_neg=0, ac_zero=1 and e_zero=1.
- R2: op_stb carries one strobe per bit. Bit 0 is AND, 1 is ADD, 2 is load DR, 3 is load char, 4 is complement, 5 is rotate right, 6 is rotate left, 7 is clear, 8 is increment, 9 is clear link and 10 is complement link. At most one of bits 0 to 8 is set in a cycle, and at most one of bits 1, 5, 6, 9 and 10 is set. With no bit set, the accumulator and the link keep their values.
- R3: AND (bit 0) loads the accumulator with accumulator AND dr_in at the next edge. The link is unchanged.
- R4: ADD (bit 1) loads the accumulator with (accumulator + dr_in) mod 65536 and loads the link with the carry out of bit 15.
- R5: Load DR (bit 2) copies dr_in into the accumulator. The link is unchanged.
- R6: Load char (bit 3) replaces accumulator bits 7 to 0 with inpr_in. Bits 15 to 8 and the link are unchanged.
- R7: Complement (bit 4) inverts every accumulator bit. The link is unchanged.
- R8: Rotate right (bit 5) rotates the 17-bit value {link, accumulator} right by one. The link goes to accumulator bit 15 and accumulator bit 0 goes to the link.
- R9: Rotate left (bit 6) rotates {link, accumulator} left by one. The link goes to accumulator bit 0 and accumulator bit 15 goes to the link.
- R10: Clear (bit 7) sets the accumulator to 0. The link is unchanged.
- R11: Increment (bit 8) adds 1 to the accumulator, so 0xFFFF becomes 0x0000. The link is unchanged.
- R12: Clear link (bit 9) sets the link to 0 and complement link (bit 10) inverts it. Neither changes the accumulator.
- R13: The flags are registered and always match the present outputs: ac_neg equals accumulator bit 15, ac_pos is its inverse, ac_zero is 1 exactly when the accumulator is 0, and e_zero is the inverse of the link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_stb | input | 11 | One-hot operation strobes (bit map in R2) |
| dr_in | input | 16 | Data-register word |
| inpr_in | input | 8 | Input-register character |
| ac_out | output | 16 | Accumulator |
| e_out | output | 1 | Link flag |
| ac_pos | output | 1 | Accumulator sign bit is clear |
| ac_neg | output | 1 | Accumulator sign bit is set |
| ac_zero | output | 1 | Accumulator is zero |
| e_zero | output | 1 | Link is zero |

## Verification
The bench targets the carry and wrap boundaries. In ADD of 0xFFFF and 0x0001 the carry must land in the link while the sum reads zero; a design that drops or misplaces the carry leaves a stale link. Increment of 0xFFFF must wrap to zero and leave the link alone; a design that routes increment through the adder would set the link. Rotations are driven with both link values and with patterns at both ends of the word, so that a plain shift, which loses or zero-fills a bit, shows up at once. Load char runs with the upper byte set, to catch a load that wipes the top byte. The flags are compared every cycle so that a flag lagging its value by a cycle is caught.

// File: rtl/acc_link_pkg.sv
package acc_link_pkg;

   localparam int NUM_OPS  = 11;
   localparam int OP_AND   = 0;
   localparam int OP_ADD   = 1;
   localparam int OP_LDDR  = 2;
   localparam int OP_LDCH  = 3;
   localparam int OP_CMP   = 4;
   localparam int OP_ROR   = 5;
   localparam int OP_ROL   = 6;
   localparam int OP_CLR   = 7;
   localparam int OP_INC   = 8;
   localparam int OP_CLRE  = 9;
   localparam int OP_CMPE  = 10;

   typedef enum logic [2:0] {
      SEL_AND  = 3'd0,
      SEL_ADD  = 3'd1,
      SEL_DR   = 3'd2,
      SEL_CHAR = 3'd3,
      SEL_CMP  = 3'd4,
      SEL_ROR  = 3'd5,
      SEL_ROL  = 3'd6
   } alu_sel_e;

   typedef struct packed {
      logic     ld;
      logic     inr;
      logic     clr;
      alu_sel_e sel;
      logic     e_ld;
      logic     e_clr;
      logic     e_cmp;
   } acc_ctrl_t;

endpackage

// File: rtl/acc_link_ctrl.sv
module acc_link_ctrl
   import acc_link_pkg::*;
(
   input  logic [NUM_OPS-1:0] op_stb,
   output acc_ctrl_t          ctrl
);

   always_comb begin
      ctrl.ld    = op_stb[OP_AND] | op_stb[OP_ADD] | op_stb[OP_LDDR] |
                   op_stb[OP_LDCH] | op_stb[OP_CMP] | op_stb[OP_ROR] |
                   op_stb[OP_ROL];
      ctrl.inr   = op_stb[OP_INC];
      ctrl.clr   = op_stb[OP_CLR];
      ctrl.e_ld  = op_stb[OP_ADD] | op_stb[OP_ROR] | op_stb[OP_ROL];
      ctrl.e_clr = op_stb[OP_CLRE];
      ctrl.e_cmp = op_stb[OP_CMPE];
      if (op_stb[OP_ADD])
         ctrl.sel = SEL_ADD;
      else if (op_stb[OP_LDDR])
         ctrl.sel = SEL_DR;
      else if (op_stb[OP_LDCH])
         ctrl.sel = SEL_CHAR;
      else if (op_stb[OP_CMP])
         ctrl.sel = SEL_CMP;
      else if (op_stb[OP_ROR])
         ctrl.sel = SEL_ROR;
      else if (op_stb[OP_ROL])
         ctrl.sel = SEL_ROL;
      else
         ctrl.sel = SEL_AND;
   end

endmodule

// File: rtl/acc_link_alu.sv
module acc_link_alu
   import acc_link_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CHAR_W       = 8,
   parameter bit RIPPLE_ADDER = 1'b1
)(
   input  logic [DATA_W-1:0] ac,
   input  logic              e,
   input  logic [DATA_W-1:0] dr,
   input  logic [CHAR_W-1:0] inpr,
   input  alu_sel_e          sel,
   output logic [DATA_W-1:0] res,
   output logic              e_res
);

   logic [DATA_W-1:0] sum;
   logic              cout;

   if (RIPPLE_ADDER) begin : g_ripple
      logic [DATA_W:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]     = ac[i] ^ dr[i] ^ carry[i];
         assign carry[i+1] = (ac[i] & dr[i]) | (carry[i] & (ac[i] ^ dr[i]));
      end
      assign cout = carry[DATA_W];
   end else begin : g_behav
      assign {cout, sum} = {1'b0, ac} + {1'b0, dr};
   end

   always_comb begin
      res   = ac & dr;
      e_res = e;
      unique case (sel)
         SEL_AND:  res = ac & dr;
         SEL_ADD:  begin res = sum; e_res = cout; end
         SEL_DR:   res = dr;
         SEL_CHAR: res = {ac[DATA_W-1:CHAR_W], inpr};
         SEL_CMP:  res = ~ac;
         SEL_ROR:  begin res = {e, ac[DATA_W-1:1]}; e_res = ac[0]; end
         SEL_ROL:  begin res = {ac[DATA_W-2:0], e}; e_res = ac[DATA_W-1]; end
         default:  res = ac & dr;
      endcase
   end

endmodule

// File: rtl/acc_link_regs.sv
module acc_link_regs
   import acc_link_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  acc_ctrl_t         ctrl,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_e,
   output logic [DATA_W-1:0] ac_q,
   output logic              e_q,
   output logic              pos_q,
   output logic              neg_q,
   output logic              zero_q,
   output logic              ezero_q
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] ac_d;
   logic              e_d;

   always_comb begin
      ac_d = ac_q;
      if (ctrl.clr)
         ac_d = '0;
      else if (ctrl.ld)
         ac_d = alu_res;
      else if (ctrl.inr)
         ac_d = ac_q + ONE;

      e_d = e_q;
      if (ctrl.e_clr)
         e_d = 1'b0;
      else if (ctrl.e_cmp)
         e_d = ~e_q;
      else if (ctrl.e_ld)
         e_d = alu_e;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q    <= '0;
         e_q     <= 1'b0;
         pos_q   <= 1'b1;
         neg_q   <= 1'b0;
         zero_q  <= 1'b1;
         ezero_q <= 1'b1;
      end else begin
         ac_q    <= ac_d;
         e_q     <= e_d;
         pos_q   <= ~ac_d[DATA_W-1];
         neg_q   <= ac_d[DATA_W-1];
         zero_q  <= (ac_d == '0);
         ezero_q <= ~e_d;
      end
   end

endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
   import acc_link_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CHAR_W       = 8,
   parameter bit RIPPLE_ADDER = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OPS-1:0] op_stb,
   input  logic [DATA_W-1:0]  dr_in,
   input  logic [CHAR_W-1:0]  inpr_in,
   output logic [DATA_W-1:0]  ac_out,
   output logic               e_out,
   output logic               ac_pos,
   output logic               ac_neg,
   output logic               ac_zero,
   output logic               e_zero
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("acc_link_unit: DATA_W must be at least 2");
   end
   if (CHAR_W < 1 || CHAR_W >= DATA_W) begin : g_bad_char_w
      $error("acc_link_unit: CHAR_W must lie in 1..DATA_W-1");
   end

   acc_ctrl_t         ctrl;
   logic [DATA_W-1:0] alu_res;
   logic              alu_e;

   acc_link_ctrl u_ctrl (
      .op_stb (op_stb),
      .ctrl   (ctrl)
   );

   acc_link_alu #(
      .DATA_W       (DATA_W),
      .CHAR_W       (CHAR_W),
      .RIPPLE_ADDER (RIPPLE_ADDER)
   ) u_alu (
      .ac    (ac_out),
      .e     (e_out),
      .dr    (dr_in),
      .inpr  (inpr_in),
      .sel   (ctrl.sel),
      .res   (alu_res),
      .e_res (alu_e)
   );

   acc_link_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (ctrl),
      .alu_res (alu_res),
      .alu_e   (alu_e),
      .ac_q    (ac_out),
      .e_q     (e_out),
      .pos_q   (ac_pos),
      .neg_q   (ac_neg),
      .zero_q  (ac_zero),
      .ezero_q (e_zero)
   );

endmodule

// File: rtl/acc_link_chk.sv
module acc_link_chk
   import acc_link_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CHAR_W = 8
)(
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OPS-1:0] op_stb,
   input logic [DATA_W-1:0]  dr_in,
   input logic [CHAR_W-1:0]  inpr_in,
   input logic [DATA_W-1:0]  ac_out,
   input logic               e_out,
   input logic               ac_pos,
   input logic               ac_neg,
   input logic               ac_zero,
   input logic               e_zero
);

   logic [DATA_W-1:0] ones;
   assign ones = '1;

   assert_ac_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_stb[OP_INC:OP_AND]));
   assert_e_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_stb[OP_ADD], op_stb[OP_ROR], op_stb[OP_ROL],
                op_stb[OP_CLRE], op_stb[OP_CMPE]}));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_stb == '0) |=> ($stable(ac_out) && $stable(e_out)));
   assert_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_AND] |=> (ac_out == ($past(ac_out) & $past(dr_in))));
   assert_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_LDCH] |=> (ac_out == {$past(ac_out[DATA_W-1:CHAR_W]), $past(inpr_in)}));
   assert_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_CMP] |=> (ac_out == ($past(ac_out) ^ ones)));
   assert_ror_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_ROR] |=> (e_out == $past(ac_out[0]) && ac_out[DATA_W-1] == $past(e_out)));
   assert_rol_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_ROL] |=> (e_out == $past(ac_out[DATA_W-1]) && ac_out[0] == $past(e_out)));
   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_CLR] |=> (ac_out == '0));
   assert_inc_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_INC] |=> (e_out == $past(e_out)));
   assert_link_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_CLRE] |=> (!e_out && $stable(ac_out)));
   assert_link_cmp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      op_stb[OP_CMPE] |=> (e_out != $past(e_out) && $stable(ac_out)));
   assert_flag_sign_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (ac_neg == ac_out[DATA_W-1]) && (ac_pos != ac_neg));
   assert_flag_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (ac_zero == (ac_out == '0)) && (e_zero != e_out));

endmodule

bind acc_link_unit acc_link_chk #(
   .DATA_W (DATA_W),
   .CHAR_W (CHAR_W)
) u_acc_link_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_stb  (op_stb),
   .dr_in   (dr_in),
   .inpr_in (inpr_in),
   .ac_out  (ac_out),
   .e_out   (e_out),
   .ac_pos  (ac_pos),
   .ac_neg  (ac_neg),
   .ac_zero (ac_zero),
   .e_zero  (e_zero)
);

// File: tb/acc_link_unit_tb_top.sv
`timescale 1ns/1ps
module acc_link_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] op_stb = '0;
   logic [15:0] dr_in = '0;
   logic [7:0]  inpr_in = '0;
   logic [15:0] ac_out;
   logic        e_out, ac_pos, ac_neg, ac_zero, e_zero;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   int m_ac = 0;
   int m_e  = 0;
   int last_op = -1;

   always #2.5 clk = ~clk;

   acc_link_unit dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_stb  (op_stb),
      .dr_in   (dr_in),
      .inpr_in (inpr_in),
      .ac_out  (ac_out),
      .e_out   (e_out),
      .ac_pos  (ac_pos),
      .ac_neg  (ac_neg),
      .ac_zero (ac_zero),
      .e_zero  (e_zero)
   );

   function automatic string tag_of(int op);
      case (op)
         0: return "R3";   1: return "R4";   2: return "R5";
         3: return "R6";   4: return "R7";   5: return "R8";
         6: return "R9";   7: return "R10";  8: return "R11";
         9: return "R12";  10: return "R12";
         default: return "R2";
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, "ac", int'(ac_out), m_ac);
      check(tag, "e", int'(e_out), m_e);
      check("R13", "ac_neg", int'(ac_neg), (m_ac >> 15) & 1);
      check("R13", "ac_pos", int'(ac_pos), ((m_ac >> 15) & 1) ^ 1);
      check("R13", "ac_zero", int'(ac_zero), (m_ac == 0) ? 1 : 0);
      check("R13", "e_zero", int'(e_zero), m_e ^ 1);
   endtask

   // apply the op to the reference model
   task automatic model(int op, int dr, int ch);
      int v;
      case (op)
         0: m_ac = m_ac & dr;
         1: begin v = m_ac + dr; m_ac = v % 65536; m_e = v / 65536; end
         2: m_ac = dr;
         3: m_ac = (m_ac / 256) * 256 + ch;
         4: m_ac = 65535 - m_ac;
         5: begin
               v = m_e * 65536 + m_ac;
               v = (v / 2) + (v % 2) * 65536;
               m_ac = v % 65536; m_e = v / 65536;
            end
         6: begin
               v = m_e * 65536 + m_ac;
               v = (v * 2) % 131072 + (v / 65536);
               m_ac = v % 65536; m_e = v / 65536;
            end
         7: m_ac = 0;
         8: m_ac = (m_ac + 1) % 65536;
         9: m_e = 0;
         10: m_e = 1 - m_e;
         default: ;
      endcase
   endtask

   // one cycle: called at negedge; compare result of previous op, drive next
   task automatic step(int op, int dr, int ch);
      if (last_op != -2) compare_all(tag_of(last_op));
      op_stb  = (op >= 0) ? (11'd1 << op) : 11'd0;
      dr_in   = dr[15:0];
      inpr_in = ch[7:0];
      model(op, dr, ch);
      last_op = op;
      @(negedge clk);
   endtask

   initial begin
      last_op = -2;
      repeat (3) @(negedge clk);
      // R1: values held in reset
      check("R1", "ac in reset", int'(ac_out), 0);
      check("R1", "pos in reset", int'(ac_pos), 1);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");
      last_op = -1;
      // directed corners
      step(-1, 16'h1234, 8'h00);           // idle: hold (R2)
      step(2, 16'hFFFF, 0);                // load DR
      step(1, 16'h0001, 0);                // add with carry -> 0, E=1
      step(-1, 0, 0);
      step(8, 0, 0);                       // inc 0 -> 1, E kept
      step(2, 16'hFFFF, 0);
      step(8, 0, 0);                       // inc wrap, E kept
      step(5, 0, 0);                       // ROR with E=1
      step(6, 0, 0);                       // ROL
      step(2, 16'h8001, 0);
      step(6, 0, 0);                       // ROL with AC[15]=1
      step(5, 0, 0);
      step(5, 0, 0);                       // ROR with AC[0]=1
      step(2, 16'hAB00, 0);
      step(3, 0, 8'hC5);                   // char load keeps high byte
      step(0, 16'h0FF0, 0);                // AND
      step(4, 0, 0);                       // complement
      step(9, 0, 0);                       // clear E
      step(10, 0, 0);                      // complement E
      step(10, 0, 0);
      step(7, 0, 0);                       // clear AC
      step(-1, 0, 0);
      // pseudo-random one-hot sequence
      for (int i = 0; i < 3000; i++) begin
         int op;
         op = int'($urandom_range(0, 11)) - 1;
         step(op, int'($urandom_range(0, 65535)), int'($urandom_range(0, 255)));
      end
      step(-1, 0, 0);
      compare_all("R2");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog actual=0x0 expected=0x1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule